// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a serial-bus target that holds a bank of byte-wide configuration registers for the rest of the chip. It samples the SCL and SDA lines on the fast system clock and cleans them up. It then detects start, repeated start and stop conditions and runs the transfer protocol. It answers only to its own write address (0xD2) and read address (0xD3). It pulls SDA low to acknowledge a byte and to send a zero data bit, and it never drives SDA high.

A write transfer carries a starting register index and a byte count, then the data bytes. The bytes land in consecutive registers. A read transfer first sets the index with a short write, then issues a repeated start with the read address. The target returns the value of its readback-count register first, then the register contents from the index upward. Stores honour per-bit masks: read-only bits keep their reset value, and sticky bits can be set but only reset clears them. The whole register image is presented on a flat output bus.

Top module: `smb_blk_target`

## Requirements
- R1: The target acknowledges the address byte 0xD2 (write) and 0xD3 (read). Any other address byte is left unacknowledged and the target ignores the bus until the next start or stop.
- R2: A write transfer has the form start, 0xD2, index N, count X, then data bytes. Each of these bytes is acknowledged, and data byte k (from 0) is stored into register N+k.
- R3: The target drives SDA low through the whole ninth clock of every byte it acknowledges. SDA is never changed while SCL is high, except for the release that follows a start or stop.
- R4: A read transfer has the form start, 0xD2, index N, repeated start, 0xD3. The target then sends the readback-count register, followed by registers N, N+1, and so on, most significant bit first. It keeps sending while the host acknowledges and stops when the host does not.
- R5: Read-only bits ignore writes. These are bits 7 and 0 of register 0, all of register 7 (value 0x01), all of register 8 (value 0x30) and bits 7:6 of register 12.
- R6: Bit 4 of register 0 is sticky. Once written to 1, a later write of 0 leaves it at 1 until reset.
- R7: After reset, register 0 reads 0x04, register 4 reads 0xFF, register 7 reads 0x01, register 8 reads 0x30, register 12 reads 0x0D and all other registers read 0x00. SDA is released.
- R8: Register 12 is the readback count. Only its low 6 bits are writable, and a written value above 32 is stored as 32.
- R9: Registers exist at indices 0 to 12. A read at a higher index returns 0x00. A write there is acknowledged and discarded.
- R10: Data bytes beyond the byte count of a write transfer are not acknowledged and are not stored.
- R11: A stop or start in any state returns the protocol to its idle or address phase and releases SDA. Registers already stored keep their values.
- R12: A pulse on SCL or SDA lasting a single system clock has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| regs_o | output | NUM_REGS*8 | Register image, register i at bits [8i+7:8i] |

## Verification
The bench builds the block with its defaults: 13 registers, a two-flop synchroniser and a three-tap majority filter. With these values a single-clock pulse is always outvoted, which makes glitch rejection on SCL testable. The count register sits at index 12, so a read can return both the clamped count and out-of-range zeros within one short transfer. SCL runs at a small multiple of the system clock instead of 100 kHz. This keeps write, read, abort and mask cases inside the cycle budget while still leaving several filter latencies between SCL and SDA edges.

// File: rtl/smb_pkg.sv
package smb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_TXACK,
      ST_WAIT
   } bus_state_t;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_INDEX,
      PH_COUNT,
      PH_DATA
   } rx_phase_t;

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_TAPS   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   localparam int HALF = FILT_TAPS / 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if ((FILT_TAPS % 2) == 0) begin : g_bad_taps
      $error("FILT_TAPS must be odd");
   end

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
   end

   if (FILT_TAPS == 1) begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dout <= 1'b1;
         else        dout <= sync_q[SYNC_STAGES-1];
      end
   end else begin : g_major
      logic [FILT_TAPS-1:0] taps_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            taps_q <= '1;
            dout   <= 1'b1;
         end else begin
            taps_q <= {taps_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
            dout   <= ($countones(taps_q) > HALF);
         end
      end
   end
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   assign scl_rise  = scl & ~scl_q;
   assign scl_fall  = ~scl & scl_q;
   assign start_det = scl & scl_q & sda_q & ~sda;
   assign stop_det  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
   parameter int                    NUM_REGS    = 13,
   parameter int                    IDX_W       = 8,
   parameter int                    CNT_IDX     = 12,
   parameter int                    CNT_BITS    = 6,
   parameter int                    CNT_MAX     = 32,
   parameter logic [NUM_REGS*8-1:0] RST_VAL     = '0,
   parameter logic [NUM_REGS*8-1:0] RO_MASK     = '0,
   parameter logic [NUM_REGS*8-1:0] STICKY_MASK = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [7:0]            wr_data,
   input  logic [IDX_W-1:0]      rd_idx,
   output logic [7:0]            rd_data,
   output logic [NUM_REGS*8-1:0] regs_flat
);
   localparam int PAD_BITS = 8 - CNT_BITS;

   if (CNT_BITS > 8 || CNT_MAX >= (1 << CNT_BITS)) begin : g_bad_cnt
      $error("count register cannot hold CNT_MAX");
   end
   if (NUM_REGS >= (1 << IDX_W) || CNT_IDX >= NUM_REGS) begin : g_bad_map
      $error("register map does not fit the index");
   end

   logic [7:0] regs_arr [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [7:0] q;
      logic       hit;
      assign hit = wr_en && (wr_idx == IDX_W'(i));
      if (i == CNT_IDX) begin : g_cnt
         logic [CNT_BITS-1:0] field;
         assign field = (wr_data[CNT_BITS-1:0] > CNT_BITS'(CNT_MAX)) ?
                        CNT_BITS'(CNT_MAX) : wr_data[CNT_BITS-1:0];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= RST_VAL[i*8 +: 8];
            else if (hit) q <= {PAD_BITS'(0), field};
         end
      end else begin : g_std
         localparam logic [7:0] RO = RO_MASK[i*8 +: 8];
         localparam logic [7:0] ST = STICKY_MASK[i*8 +: 8];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= RST_VAL[i*8 +: 8];
            else if (hit) q <= (q & RO) | (wr_data & ~RO) | (q & ST);
         end
      end
      assign regs_arr[i]      = q;
      assign regs_flat[i*8 +: 8] = q;
   end

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_idx == IDX_W'(i)) rd_data = regs_arr[i];
      end
   end

   p_cnt_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
      regs_arr[CNT_IDX] <= 8'(CNT_MAX))
      else $error("count register above its maximum");

   p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(regs_flat) & STICKY_MASK & ~regs_flat) == '0)
      else $error("sticky bit cleared");

   p_oob_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx >= IDX_W'(NUM_REGS)) |=> $stable(regs_flat))
      else $error("out of range write changed the bank");
endmodule

// File: rtl/smb_blk_target.sv
module smb_blk_target
   import smb_pkg::*;
#(
   parameter int                    NUM_REGS    = 13,
   parameter int                    SYNC_STAGES = 2,
   parameter int                    FILT_TAPS   = 3,
   parameter int                    CNT_IDX     = 12,
   parameter int                    CNT_BITS    = 6,
   parameter int                    CNT_MAX     = 32,
   parameter logic [7:0]            WR_ADDR     = 8'hD2,
   parameter logic [NUM_REGS*8-1:0] RST_VAL     = 104'h0D_00_00_00_30_01_00_00_FF_00_00_00_04,
   parameter logic [NUM_REGS*8-1:0] RO_MASK     = 104'hC0_00_00_00_FF_FF_00_00_00_00_00_00_81,
   parameter logic [NUM_REGS*8-1:0] STICKY_MASK = 104'h00_00_00_00_00_00_00_00_00_00_00_00_10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe_o,
   output logic [NUM_REGS*8-1:0] regs_o
);
   localparam int         IDX_W   = 8;
   localparam logic [7:0] RD_ADDR = WR_ADDR | 8'h01;

   if (WR_ADDR[0] != 1'b0) begin : g_bad_addr
      $error("WR_ADDR must have bit 0 clear");
   end

   logic [1:0] raw_lines, clean_lines;
   assign raw_lines = {scl_i, sda_i};

   for (genvar g = 0; g < 2; g++) begin : g_filt
      smb_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_TAPS(FILT_TAPS)) u_filt (
         .clk (clk),
         .rst_n(rst_n),
         .din (raw_lines[g]),
         .dout(clean_lines[g])
      );
   end

   logic scl_f, sda_f;
   assign scl_f = clean_lines[1];
   assign sda_f = clean_lines[0];

   logic scl_rise, scl_fall, start_det, stop_det;

   smb_bus_events u_events (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl      (scl_f),
      .sda      (sda_f),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   bus_state_t       state;
   rx_phase_t        phase;
   logic [3:0]       bitcnt;
   logic [7:0]       rx_sh, tx_sh;
   logic [IDX_W-1:0] ptr;
   logic [7:0]       remain;
   logic             drv_q, ack_to_tx, host_ack;
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic [7:0]       wr_data, rd_data, cnt_val;

   smb_reg_bank #(
      .NUM_REGS   (NUM_REGS),
      .IDX_W      (IDX_W),
      .CNT_IDX    (CNT_IDX),
      .CNT_BITS   (CNT_BITS),
      .CNT_MAX    (CNT_MAX),
      .RST_VAL    (RST_VAL),
      .RO_MASK    (RO_MASK),
      .STICKY_MASK(STICKY_MASK)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .rd_idx   (ptr),
      .rd_data  (rd_data),
      .regs_flat(regs_o)
   );

   assign cnt_val  = regs_o[CNT_IDX*8 +: 8];
   assign sda_oe_o = drv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         phase     <= PH_ADDR;
         bitcnt    <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         ptr       <= '0;
         remain    <= '0;
         drv_q     <= 1'b0;
         ack_to_tx <= 1'b0;
         host_ack  <= 1'b0;
         wr_en     <= 1'b0;
         wr_idx    <= '0;
         wr_data   <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            state  <= ST_RX;
            phase  <= PH_ADDR;
            bitcnt <= '0;
            drv_q  <= 1'b0;
         end else if (stop_det) begin
            state <= ST_IDLE;
            drv_q <= 1'b0;
         end else begin
            case (state)
               ST_RX: begin
                  if (scl_rise && bitcnt != 4'd8) begin
                     rx_sh  <= {rx_sh[6:0], sda_f};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     bitcnt    <= '0;
                     state     <= ST_ACK;
                     drv_q     <= 1'b1;
                     ack_to_tx <= 1'b0;
                     case (phase)
                        PH_ADDR: begin
                           if (rx_sh == WR_ADDR) begin
                              phase <= PH_INDEX;
                           end else if (rx_sh == RD_ADDR) begin
                              ack_to_tx <= 1'b1;
                              tx_sh     <= cnt_val;
                           end else begin
                              state <= ST_WAIT;
                              drv_q <= 1'b0;
                           end
                        end
                        PH_INDEX: begin
                           ptr   <= rx_sh;
                           phase <= PH_COUNT;
                        end
                        PH_COUNT: begin
                           remain <= rx_sh;
                           phase  <= PH_DATA;
                        end
                        default: begin
                           if (remain != 8'd0) begin
                              wr_en   <= 1'b1;
                              wr_idx  <= ptr;
                              wr_data <= rx_sh;
                              ptr     <= ptr + 8'd1;
                              remain  <= remain - 8'd1;
                           end else begin
                              state <= ST_WAIT;
                              drv_q <= 1'b0;
                           end
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     if (ack_to_tx) begin
                        state <= ST_TX;
                        drv_q <= ~tx_sh[7];
                     end else begin
                        state <= ST_RX;
                        drv_q <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bitcnt == 4'd8) begin
                        drv_q  <= 1'b0;
                        bitcnt <= '0;
                        state  <= ST_TXACK;
                     end else begin
                        tx_sh <= {tx_sh[6:0], 1'b0};
                        drv_q <= ~tx_sh[6];
                     end
                  end
               end
               ST_TXACK: begin
                  if (scl_rise) begin
                     host_ack <= ~sda_f;
                  end else if (scl_fall) begin
                     if (host_ack) begin
                        tx_sh <= rd_data;
                        ptr   <= ptr + 8'd1;
                        drv_q <= ~rd_data[7];
                        state <= ST_TX;
                     end else begin
                        state <= ST_WAIT;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_f && $past(scl_f) && !$past(start_det || stop_det)) |-> $stable(sda_oe_o))
      else $error("SDA drive changed while SCL high");

   p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe_o)
      else $error("SDA still driven after stop");
endmodule

// File: tb/sim_smb_blk_target.sv
module sim_smb_blk_target;
   localparam int NREG = 13;
   localparam int Q    = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic h_scl = 1'b1;
   logic h_sda = 1'b1;
   logic sda_oe;
   logic [NREG*8-1:0] regs;
   wire  sda_line = h_sda & ~sda_oe;

   always #4 clk = ~clk;

   smb_blk_target u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (h_scl),
      .sda_i   (sda_line),
      .sda_oe_o(sda_oe),
      .regs_o  (regs)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0] mdl [NREG];
   logic [7:0] ro  [NREG];
   logic [7:0] st  [NREG];
   logic [7:0] wbuf [16];

   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic [7:0] got_byte;
   event       got_ev;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: compares each byte read from the target
   always @(got_ev) begin
      if (exp_q.size() == 0) begin
         chk(1'b0, "R4 unexpected byte", {24'd0, got_byte}, 32'hFFFF);
      end else begin
         automatic logic [7:0] e = exp_q.pop_front();
         automatic string t = tag_q.pop_front();
         chk(got_byte == e, t, {24'd0, got_byte}, {24'd0, e});
      end
   end

   function automatic void mdl_write(input int idx, input logic [7:0] v);
      if (idx >= NREG) return;
      if (idx == 12) begin
         automatic logic [5:0] f = v[5:0];
         if (f > 6'd32) f = 6'd32;
         mdl[12] = {2'b00, f};
      end else begin
         mdl[idx] = (mdl[idx] & ro[idx]) | (v & ~ro[idx]) | (mdl[idx] & st[idx]);
      end
   endfunction

   function automatic logic [7:0] mdl_read(input int idx);
      return (idx < NREG) ? mdl[idx] : 8'h00;
   endfunction

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      h_sda = 1'b1; wq();
      h_scl = 1'b1; wq();
      h_sda = 1'b0; wq();
      h_scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      h_sda = 1'b0; wq();
      h_scl = 1'b1; wq();
      h_sda = 1'b1; wq();
   endtask

   task automatic send_bit(input logic b, input bit glitch);
      if (glitch) begin
         @(negedge clk) h_scl = 1'b1;
         @(negedge clk) h_scl = 1'b0;
      end
      h_sda = b; wq();
      h_scl = 1'b1; wq(); wq();
      h_scl = 1'b0; wq();
   endtask

   task automatic recv_bit(output logic b);
      h_sda = 1'b1; wq();
      h_scl = 1'b1; wq();
      b = sda_line; wq();
      h_scl = 1'b0; wq();
   endtask

   task automatic write_byte(input logic [7:0] v, input bit glitch, output bit acked);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(v[i], glitch && (i == 4));
      recv_bit(a);
      acked = ~a;
   endtask

   task automatic read_byte(input bit host_ack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         v[i] = b;
      end
      send_bit(~host_ack, 1'b0);
   endtask

   task automatic blk_write(input int idx, input int cnt, input int n, input bit glitch, input string req);
      bit a;
      bus_start();
      write_byte(8'hD2, 1'b0, a); chk(a, {req, " R1 write address ack"}, {31'd0, a}, 1);
      write_byte(8'(idx), 1'b0, a); chk(a, {req, " R2 index ack"}, {31'd0, a}, 1);
      write_byte(8'(cnt), 1'b0, a); chk(a, {req, " R2 count ack"}, {31'd0, a}, 1);
      for (int i = 0; i < n; i++) begin
         write_byte(wbuf[i], glitch, a);
         chk(a == (i < cnt), {req, " R10 data ack"}, {31'd0, a}, {31'd0, (i < cnt)});
         if (!a) break;
         mdl_write(idx + i, wbuf[i]);
      end
      bus_stop();
   endtask

   task automatic blk_read(input int idx, input int n, input string req);
      bit a;
      logic [7:0] v;
      bus_start();
      write_byte(8'hD2, 1'b0, a); chk(a, {req, " R1 write address ack"}, {31'd0, a}, 1);
      write_byte(8'(idx), 1'b0, a); chk(a, {req, " R4 index ack"}, {31'd0, a}, 1);
      bus_start();
      write_byte(8'hD3, 1'b0, a); chk(a, {req, " R1 read address ack"}, {31'd0, a}, 1);
      exp_q.push_back(mdl[12]); tag_q.push_back({req, " R8 count byte"});
      read_byte(1'b1, v); got_byte = v; ->got_ev;
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(mdl_read(idx + i)); tag_q.push_back({req, " R4 data byte"});
         read_byte(i != n - 1, v); got_byte = v; ->got_ev;
      end
      bus_stop();
      chk(sda_oe == 1'b0, {req, " R11 released after stop"}, {31'd0, sda_oe}, 0);
   endtask

   task automatic cmp_regs(input string req);
      for (int i = 0; i < NREG; i++)
         chk(regs[i*8 +: 8] == mdl[i], req, {24'd0, regs[i*8 +: 8]}, {24'd0, mdl[i]});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      bit a;
      for (int i = 0; i < NREG; i++) begin mdl[i] = 8'h00; ro[i] = 8'h00; st[i] = 8'h00; end
      mdl[0] = 8'h04; mdl[4] = 8'hFF; mdl[7] = 8'h01; mdl[8] = 8'h30; mdl[12] = 8'h0D;
      ro[0] = 8'h81; ro[7] = 8'hFF; ro[8] = 8'hFF; ro[12] = 8'hC0;
      st[0] = 8'h10;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      cmp_regs("R7 reset value");
      chk(sda_oe == 1'b0, "R7 SDA released", {31'd0, sda_oe}, 0);

      // R2 plain block write, then R4 block read back
      wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
      blk_write(1, 3, 3, 1'b0, "R2");
      cmp_regs("R2 stored bytes");
      blk_read(1, 4, "R4");

      // R5 and R6: masks on register 0, read-only register 7
      wbuf[0] = 8'hFF;
      blk_write(0, 1, 1, 1'b0, "R6 set");
      wbuf[0] = 8'h00;
      blk_write(0, 1, 1, 1'b0, "R6 clear");
      chk(regs[7:0] == 8'h10, "R6 sticky bit kept", {24'd0, regs[7:0]}, 32'h10);
      wbuf[0] = 8'hEE; wbuf[1] = 8'h55;
      blk_write(7, 2, 2, 1'b0, "R5");
      chk(regs[63:56] == 8'h01 && regs[71:64] == 8'h30, "R5 read-only",
          {16'd0, regs[71:56]}, 32'h3001);
      cmp_regs("R5 bank");

      // R8 count clamp and readback
      wbuf[0] = 8'hFF;
      blk_write(12, 1, 1, 1'b0, "R8 clamp");
      chk(regs[103:96] == 8'h20, "R8 clamp to 32", {24'd0, regs[103:96]}, 32'h20);
      blk_read(11, 3, "R9 edge read");
      wbuf[0] = 8'h1F;
      blk_write(12, 1, 1, 1'b0, "R8 small");
      chk(regs[103:96] == 8'h1F, "R8 stored", {24'd0, regs[103:96]}, 32'h1F);

      // R9 out of range write: acked, discarded
      wbuf[0] = 8'h77; wbuf[1] = 8'h88;
      blk_write(20, 2, 2, 1'b0, "R9");
      cmp_regs("R9 no change");
      blk_read(20, 2, "R9 read zero");

      // R10 bytes beyond the count
      wbuf[0] = 8'h3C; wbuf[1] = 8'h99;
      blk_write(5, 1, 2, 1'b0, "R10");
      cmp_regs("R10 extra discarded");

      // R1 foreign address
      bus_start();
      write_byte(8'hA0, 1'b0, a); chk(!a, "R1 foreign address nack", {31'd0, a}, 0);
      write_byte(8'h02, 1'b0, a); chk(!a, "R1 ignored after nack", {31'd0, a}, 0);
      bus_stop();
      cmp_regs("R1 no change");

      // R11 stop in the middle of a data byte
      bus_start();
      write_byte(8'hD2, 1'b0, a);
      write_byte(8'h02, 1'b0, a);
      write_byte(8'h02, 1'b0, a);
      write_byte(8'h5A, 1'b0, a); chk(a, "R11 first byte ack", {31'd0, a}, 1);
      mdl_write(2, 8'h5A);
      for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
      bus_stop();
      cmp_regs("R11 committed kept");
      chk(sda_oe == 1'b0, "R11 SDA released", {31'd0, sda_oe}, 0);

      // R12 single-clock SCL pulse inside every data byte
      wbuf[0] = 8'h6B; wbuf[1] = 8'h94;
      blk_write(9, 2, 2, 1'b1, "R12");
      cmp_regs("R12 glitch ignored");
      blk_read(9, 2, "R12 readback");

      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule